// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the current in a motor winding by switching the high-side (source) drivers off for a fixed time after the winding current reaches its limit. A sense comparator outside the block turns the current limit into a digital trip signal. The block takes that trip, the external enable used for outside PWM, and the rotation direction. It produces a source-enable signal that the commutation logic ANDs into its high-side gate commands. It also produces a flag that is high for the whole internal off period, so that the commutation logic can apply synchronous rectification while the current recirculates.

Switching the source on again causes a current spike. A blanking window guards against it by masking the trip input. The window opens when the off-time ends. It opens again when the external enable turns the outputs back on, and again when the direction input changes. All durations come from a clock-frequency parameter and nanosecond parameters, and they are counted in system clock cycles. One shared counter times both the off-time and the blanking window, because the two never run at the same time.

Top module: `chop_ctrl`

## Requirements
- R1: When the trip input is high, the external enable is high, and the block is neither in off-time nor blanking, `src_en_o` goes low and `off_time_o` goes high from the next clock cycle. In the cycle that samples the trip, `src_en_o` is still high.
- R2: The off-time lasts exactly OFF_CYC = CLK_MHZ*OFF_NS/1000 clock cycles, with a minimum of 1. In the first cycle after it ends, `src_en_o` follows the external enable again.
- R3: A trip is ignored during the BLANK_CYC = CLK_MHZ*BLANK_NS/1000 cycles that follow the end of an off-time. A trip in the next cycle after that window is accepted.
- R4: A rising edge of `ext_on_i` restarts blanking. A trip is ignored in the cycle where the enable first reads high and in the BLANK_CYC cycles after it.
- R5: Any change of `dir_i` restarts blanking with the same window as R4: the cycle of the change plus BLANK_CYC cycles.
- R6: A trip that arrives while `ext_on_i` is low starts no off-time. Raising the enable afterwards gives a source that stays on.
- R7: Outside the off-time, `src_en_o` equals `ext_on_i` within the same cycle.
- R8: `off_time_o` is high exactly during the off-time cycles and is low at all other times.
- R9: After reset the block is idle: `off_time_o` is 0 and no blanking or off-time is in progress.
- R10: A trip that arrives during an off-time neither extends nor restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the timers count |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Digitized over-current trip from the sense comparator |
| ext_on_i | input | 1 | External enable: 1 turns the outputs on, 0 chops them off |
| dir_i | input | 1 | Rotation direction; any change restarts blanking |
| src_en_o | output | 1 | Source (high-side) enable for the commutation logic |
| off_time_o | output | 1 | High for the whole internal off-time |

## Verification
On every cycle the assertions check the following: an accepted trip is always followed by an off-time; the off-time always hands over to blanking; no trip gets through while blanking or while the enable is low; a restart event always opens a blanking window; and an off-time, once started, runs to its end. The exact cycle counts are shown only by the bench's sweeps. These are the length of the off-time, the boundary of each blanking window (R3 compared with R4 and R5), and the fact that a trip ignored with the enable low leaves the source on. The sweeps place a trip at every offset across each window.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OFF   = 2'd1,
    PH_BLANK = 2'd2
  } chop_phase_e;

  // Duration in clock cycles for a time in ns at a clock in MHz, never zero.
  function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
    int unsigned c;
    c = (mhz * ns) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/chop_event_gen.sv
module chop_event_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_on_i,
  input  logic dir_i,
  output logic restart_o
);
  logic ext_q, dir_q;
  logic ext_d, dir_d;

  always_comb begin
    ext_d = ext_on_i;
    dir_d = dir_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      ext_q <= ext_d;
      dir_q <= dir_d;
    end
  end

  // Enable turning outputs on again, or a direction change
  assign restart_o = (ext_on_i & ~ext_q) | (dir_i ^ dir_q);

endmodule

// File: rtl/chop_interval_timer.sv
module chop_interval_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             expire_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == WIDTH'(1));

  // R2: expiry is a single-cycle event unless the count is reloaded
  a_r2_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !load_i |=> !expire_o);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned OFF_NS   = 25000,
  parameter int unsigned BLANK_NS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic ext_on_i,
  input  logic dir_i,
  output logic src_en_o,
  output logic off_time_o
);
  localparam int unsigned OFF_CYC   = ns_to_cycles(CLK_MHZ, OFF_NS);
  localparam int unsigned BLANK_CYC = ns_to_cycles(CLK_MHZ, BLANK_NS);
  localparam int unsigned MAX_CYC   = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);

  chop_phase_e      phase_q, phase_d;
  logic             phase_en;
  logic             restart;
  logic             trip_ok;
  logic             tmr_load, tmr_expire;
  logic [TMR_W-1:0] tmr_val;

  chop_event_gen u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_on_i  (ext_on_i),
    .dir_i     (dir_i),
    .restart_o (restart)
  );

  chop_interval_timer #(.WIDTH(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire)
  );

  assign trip_ok = trip_i & ext_on_i & ~restart;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (trip_ok) begin
          phase_d  = PH_OFF;
          tmr_load = 1'b1;
        end else if (restart) begin
          phase_d  = PH_BLANK;
          tmr_load = 1'b1;
        end
      end
      PH_OFF: begin
        if (tmr_expire) begin
          phase_d  = PH_BLANK;
          tmr_load = 1'b1;
        end
      end
      PH_BLANK: begin
        if (restart)         tmr_load = 1'b1;
        else if (tmr_expire) phase_d  = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
    tmr_val  = (phase_d == PH_OFF) ? TMR_W'(OFF_CYC) : TMR_W'(BLANK_CYC);
    phase_en = (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= PH_IDLE;
    else if (phase_en) phase_q <= phase_d;
  end

  assign off_time_o = (phase_q == PH_OFF);
  assign src_en_o   = ext_on_i & ~off_time_o;

  // R1: an accepted trip turns the source off from the next cycle
  a_r1_trip_cuts_source: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) && trip_i && ext_on_i && !restart |=> off_time_o && !src_en_o);

  // R3: the end of the off-time always opens a blanking window
  a_r3_off_hands_to_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_time_o) |-> (phase_q == PH_BLANK));

  // R3: no trip gets through while blanking
  a_r3_blank_masks_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BLANK) |=> !off_time_o);

  // R4 / R5: a restart event outside off-time always blanks
  a_r4_restart_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !off_time_o |=> (phase_q == PH_BLANK));

  // R6: trip with the enable low starts nothing
  a_r6_idle_trip_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_on_i && !off_time_o |=> !off_time_o);

  // R10: an off-time runs to its end regardless of further trips
  a_r10_off_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    off_time_o && !tmr_expire |=> off_time_o);

endmodule

// File: tb/chop_ctrl_bench.sv
`timescale 1ns/1ps
module chop_ctrl_bench;
  localparam int MHZ   = 200;
  localparam int OFFNS = 100;
  localparam int BLKNS = 40;
  localparam int OFF   = MHZ * OFFNS / 1000;
  localparam int BLK   = MHZ * BLKNS / 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic trip, ext, dir;
  logic src_en, off_t;
  int   checks = 0;
  int   fails  = 0;
  logic dc = 1'b0;

  always #2.5 clk = ~clk;

  chop_ctrl #(.CLK_MHZ(MHZ), .OFF_NS(OFFNS), .BLANK_NS(BLKNS)) u_chop_ctrl (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .ext_on_i(ext), .dir_i(dir),
    .src_en_o(src_en), .off_time_o(off_t)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: drive just after the edge, sample mid-cycle
  task automatic cyc(input logic t, input logic e, input logic d);
    @(posedge clk); #1;
    trip = t; ext = e; dir = d;
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (OFF + BLK + 3) cyc(1'b0, 1'b1, dc);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; trip = 1'b0; ext = 1'b0; dir = 1'b0;
    repeat (3) @(negedge clk);
    chk(off_t == 1'b0, "R9 off flag in reset", off_t, 0);
    chk(src_en == 1'b0, "R9 source with enable low", src_en, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc(1'b0, 1'b0, dc);
    chk(off_t == 1'b0, "R9 idle after reset", off_t, 0);

    // R7: source follows enable
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b1, dc);
      chk(src_en == 1'b1 && off_t == 1'b0, "R7 source follows enable", src_en, 1);
    end

    // R1 / R2 / R8 / R10: off-time length, with and without extra trips
    for (int poke = 0; poke < 2; poke++) begin
      cyc(1'b1, 1'b1, dc);
      chk(src_en == 1'b1, "R1 source on in trip cycle", src_en, 1);
      n = 0;
      for (int i = 0; i < 200; i++) begin
        cyc((poke == 1) && (i == 5), 1'b1, dc);
        if (!off_t) break;
        n++;
        if (i == 0) chk(src_en == 1'b0, "R1 source off after trip", src_en, 0);
      end
      chk(n == OFF, (poke == 1) ? "R10 off-time not extended" : "R2 R8 off-time length", n, OFF);
      chk(src_en == 1'b1, "R2 source back after off-time", src_en, 1);
      flush();
    end

    // R3: trip swept across the post-off blanking window
    for (int d = 1; d <= BLK + 2; d++) begin
      cyc(1'b1, 1'b1, dc);
      repeat (OFF) cyc(1'b0, 1'b1, dc);
      for (int k = 1; k <= d; k++) cyc(k == d, 1'b1, dc);
      cyc(1'b0, 1'b1, dc);
      chk(off_t == (d > BLK), "R3 blank after off-time", off_t, int'(d > BLK));
      flush();
    end

    // R4: trip swept after the enable rises
    for (int d = 1; d <= BLK + 3; d++) begin
      repeat (3) cyc(1'b0, 1'b0, dc);
      chk(src_en == 1'b0, "R7 source off with enable low", src_en, 0);
      for (int k = 1; k <= d; k++) cyc(k == d, 1'b1, dc);
      cyc(1'b0, 1'b1, dc);
      chk(off_t == (d > BLK + 1), "R4 blank after enable on", off_t, int'(d > BLK + 1));
      flush();
    end

    // R5: trip swept after a direction change
    for (int d = 1; d <= BLK + 3; d++) begin
      dc = ~dc;
      for (int k = 1; k <= d; k++) cyc(k == d, 1'b1, dc);
      cyc(1'b0, 1'b1, dc);
      chk(off_t == (d > BLK + 1), "R5 blank after direction change", off_t, int'(d > BLK + 1));
      flush();
    end

    // R6: trip with enable low is ignored
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b0, dc);
      chk(off_t == 1'b0 && src_en == 1'b0, "R6 trip ignored with enable low", off_t, 0);
    end
    for (int i = 0; i < BLK + 3; i++) begin
      cyc(1'b0, 1'b1, dc);
      chk(src_en == 1'b1 && off_t == 1'b0, "R6 source stays on afterwards", src_en, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule